// File: doc/BRIEF.md
# System Control Register Bank

This block is a bank of 32-bit control and status words reached through a single-word bus slave. A host presents an address, a write strobe with write data, and a read strobe. The block returns the addressed word one clock later. The bank decodes a 4 KiB window and accepts only word-aligned accesses. Bytes within a word are little-endian.

Each word follows one of four write policies:

- Plain storage.
- Read-only.
- Clear-on-one: each 1 in the write data clears that bit.
- Sticky set-on-one: each 1 in the write data sets that bit, and the bit stays set until the next reset.

Reset loads fixed constants into most words. Two words load from strap input vectors. One word carries a memory-size code derived from the DRAM size parameter, given as log2 of the size in bytes.

Top module: `sysctl_regbank`

## Requirements
- R1: Only accesses with `addr_i[1:0] == 0` take effect. A misaligned write changes no register, and a misaligned read returns zero.
- R2: Word index `addr_i[11:2]` selects a register. Index 81 (offset 0x144) is the last implemented word. A read above it returns zero, and a write above it changes no register.
- R3: The words at offsets 0x000, 0x004 and 0x040 are read-only. Writing to them leaves their value unchanged.
- R4: The words at offsets 0x06C and 0x0D4 are clear-on-one. After a write, the new value is the old value AND NOT the write data.
- R5: The words at offsets 0x070 and 0x07C are sticky set-on-one. After a write, the new value is the old value OR the write data. No bit can fall before reset.
- R6: After reset, the following words hold these values, and every word not listed in R6, R7 or R8 reads zero:

  | Offset | Value |
  |---|---|
  | 0x000 | 0x04A92750 |
  | 0x014 | 0x0000FFFF |
  | 0x038 | 0x00000003 |
  | 0x03C | 0x0000035E |
  | 0x050 | 0x0000004E |
  | 0x060 | 0x00080000 |
  | 0x06C | 0x80000000 |
  | 0x078 | 0x000000C0 |
  | 0x098 | 0x5A00F3CF |
  | 0x13C | 0x00000008 |
  | 0x140 | 0x034730E4 |
  | 0x144 | 0x034730E4 |

- R7: Reset loads offset 0x004 from `strap_i` and offset 0x07C from `mod_dis_i`.
- R8: Reset loads offset 0x09C with `0x1002 | ((DRAM_LOG2-27) << 8)`. Elaboration rejects a `DRAM_LOG2` outside 27..31.
- R9: Every other word from offset 0x000 to 0x144 is plain read/write storage.
- R10: `rd_data_o` updates on the clock edge that samples `rd_en_i`. It holds its value in cycles without a read, and it is zero after reset.
- R11: A read and a write to the same word in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_i | input | 32 | Reset value for offset 0x004 |
| mod_dis_i | input | 32 | Reset value for offset 0x07C |
| addr_i | input | 12 | Byte address in the window |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Registered read data |

## Verification
Some properties are checked on every cycle:

- Read-only words never change.
- Clear-on-one bits never rise.
- Sticky bits never fall.
- Reads outside the implemented range return zero.
- Read data matches the addressed word as it stood at the read edge.
- Read data holds when no read is made.

Other behaviour shows up only in the bench's scenarios against its reference model. This covers the exact reset constants, the strap and size-code loads, the clear and set arithmetic on particular data, misaligned writes that must not alias a neighbour, and a second reset that releases sticky bits.

// File: rtl/sysctl_regbank.sv
module sysctl_regbank #(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int DRAM_LOG2 = 29
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] strap_i,
  input  logic [DATA_W-1:0] mod_dis_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int NREG  = 82;
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [DATA_W-1:0] SIZE_CODE = DATA_W'(DRAM_LOG2 - 27);

  localparam logic [1:0] P_RW = 2'd0, P_RO = 2'd1, P_CLR = 2'd2, P_SET = 2'd3;

  if (DRAM_LOG2 < 27 || DRAM_LOG2 > 31) begin : g_bad_dram
    $error("DRAM_LOG2 must lie in 27..31");
  end

  function automatic logic [DATA_W-1:0] cold_val(int i);
    case (i)
      0:       return DATA_W'(32'h04A9_2750);
      5:       return DATA_W'(32'h0000_FFFF);
      14:      return DATA_W'(32'h0000_0003);
      15:      return DATA_W'(32'h0000_035E);
      20:      return DATA_W'(32'h0000_004E);
      24:      return DATA_W'(32'h0008_0000);
      27:      return DATA_W'(32'h8000_0000);
      30:      return DATA_W'(32'h0000_00C0);
      38:      return DATA_W'(32'h5A00_F3CF);
      39:      return DATA_W'(32'h0000_1002) | (SIZE_CODE << 8);
      79:      return DATA_W'(32'h0000_0008);
      80, 81:  return DATA_W'(32'h0347_30E4);
      default: return '0;
    endcase
  endfunction

  function automatic logic [1:0] policy(int i);
    case (i)
      0, 1, 16: return P_RO;
      27, 53:   return P_CLR;
      28, 31:   return P_SET;
      default:  return P_RW;
    endcase
  endfunction

  logic [DATA_W-1:0] regs [NREG];
  logic [IDX_W-1:0]  idx;
  logic              hit;
  logic [DATA_W-1:0] rd_word;

  assign idx = addr_i[ADDR_W-1:2];
  assign hit = (addr_i[1:0] == 2'b00) && (int'(idx) < NREG);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [1:0] POL = policy(g);
    wire sel = wr_en_i && hit && (idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        if (g == 1)       regs[g] <= strap_i;
        else if (g == 31) regs[g] <= mod_dis_i;
        else              regs[g] <= cold_val(g);
      end else if (sel) begin
        case (POL)
          P_RO:    regs[g] <= regs[g];
          P_CLR:   regs[g] <= regs[g] & ~wr_data_i;
          P_SET:   regs[g] <= regs[g] | wr_data_i;
          default: regs[g] <= wr_data_i;
        endcase
      end
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NREG; i++)
      if (hit && idx == IDX_W'(i)) rd_word = regs[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= rd_word;
  end
endmodule

// File: rtl/sysctl_regbank_chk.sv
module sysctl_regbank_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int NREG   = 82
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rd_en_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [DATA_W-1:0] regs [NREG]
);
  logic              in_rng;
  logic [DATA_W-1:0] seen;

  assign in_rng = (addr_i[1:0] == 2'b00) && (int'(addr_i[ADDR_W-1:2]) < NREG);

  always_comb begin
    seen = '0;
    for (int i = 0; i < NREG; i++)
      if (int'(addr_i[ADDR_W-1:2]) == i) seen = regs[i];
  end

  assert_ro_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ($stable(regs[0]) && $stable(regs[1]) && $stable(regs[16])));

  assert_clr_no_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (((regs[27] & ~$past(regs[27])) == '0) &&
                      ((regs[53] & ~$past(regs[53])) == '0)));

  assert_set_no_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (((~regs[28] & $past(regs[28])) == '0) &&
                      ((~regs[31] & $past(regs[31])) == '0)));

  assert_oob_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !in_rng) |=> (rd_data_o == '0));

  assert_rd_old_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && in_rng) |=> (rd_data_o == $past(seen)));

  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

bind sysctl_regbank sysctl_regbank_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREG(NREG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .rd_en_i(rd_en_i),
  .rd_data_o(rd_data_o), .regs(regs)
);

// File: tb/tb_sysctl_regbank.sv
module tb_sysctl_regbank;
  localparam int LOG2 = 30;
  localparam int NW   = 82;

  logic        clk = 0, rst_n = 0;
  logic [31:0] strap_i = 32'hA5A5_0F0F, mod_dis_i = 32'h0000_0011;
  logic [11:0] addr_i = '0;
  logic        wr_en_i = 0, rd_en_i = 0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;

  sysctl_regbank #(.DRAM_LOG2(LOG2)) dut (.*);

  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] mdl [NW];
  logic [31:0] last_rd;

  function automatic logic [31:0] boot_val(int w);
    case (w * 4)
      'h000: return 32'h04A92750;  'h004: return strap_i;
      'h014: return 32'h0000FFFF;  'h038: return 32'h00000003;
      'h03C: return 32'h0000035E;  'h050: return 32'h0000004E;
      'h060: return 32'h00080000;  'h06C: return 32'h80000000;
      'h078: return 32'h000000C0;  'h07C: return mod_dis_i;
      'h098: return 32'h5A00F3CF;  'h09C: return 32'h1002 | ((LOG2 - 27) << 8);
      'h13C: return 32'h00000008;  'h140, 'h144: return 32'h034730E4;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int w);
    case (w * 4)
      'h000, 'h004, 'h040: return "R3";
      'h06C, 'h0D4: return "R4";
      'h070, 'h07C: return "R5";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic load_model();
    for (int w = 0; w < NW; w++) mdl[w] = boot_val(w);
  endtask

  task automatic op(logic [11:0] a, bit we, logic [31:0] wd, bit re, string req);
    int w; bit ok; logic [31:0] exp;
    w = int'(a[11:2]);
    ok = (a[1:0] == 0) && (w < NW);
    exp = ok ? mdl[w] : 32'h0;
    addr_i = a; wr_en_i = we; wr_data_i = wd; rd_en_i = re;
    @(negedge clk);
    if (re) begin check(req, rd_data_o, exp); last_rd = exp; end
    else check("R10", rd_data_o, last_rd);
    if (we && ok) begin
      case (tag_of(w))
        "R3": ;
        "R4": mdl[w] = mdl[w] & ~wd;
        "R5": mdl[w] = mdl[w] | wd;
        default: mdl[w] = wd;
      endcase
    end
    wr_en_i = 0; rd_en_i = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    #35;
    load_model();
    last_rd = 0;
    @(negedge clk);
    check("R10", rd_data_o, 32'h0);
    rst_n = 1;
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    // R6 R7 R8: reset contents of every word
    for (int w = 0; w < NW; w++)
      op(12'(w * 4), 0, 0, 1, (w == 1 || w == 31) ? "R7" : (w == 39) ? "R8" : "R6");
    // R3 read-only words
    op(12'h000, 1, 32'hFFFF_FFFF, 0, "R3");
    op(12'h004, 1, 32'h0, 0, "R3");
    op(12'h040, 1, 32'h1234_5678, 0, "R3");
    op(12'h000, 0, 0, 1, "R3");
    op(12'h004, 0, 0, 1, "R3");
    op(12'h040, 0, 0, 1, "R3");
    // R4 clear-on-one
    op(12'h06C, 1, 32'h0000_0001, 1, "R4");
    op(12'h06C, 0, 0, 1, "R4");
    op(12'h06C, 1, 32'h8000_0000, 0, "R4");
    op(12'h06C, 0, 0, 1, "R4");
    op(12'h0D4, 1, 32'hFFFF_FFFF, 0, "R4");
    op(12'h0D4, 0, 0, 1, "R4");
    // R5 sticky set
    op(12'h070, 1, 32'h0000_00F0, 0, "R5");
    op(12'h070, 1, 32'h0000_000F, 0, "R5");
    op(12'h070, 1, 32'h0, 0, "R5");
    op(12'h070, 0, 0, 1, "R5");
    op(12'h07C, 1, 32'h0100_0000, 0, "R5");
    op(12'h07C, 0, 0, 1, "R5");
    // R9 plain storage and R11 same-cycle read/write
    op(12'h100, 1, 32'hCAFE_F00D, 0, "R9");
    op(12'h100, 1, 32'h1111_2222, 1, "R11");
    op(12'h100, 0, 0, 1, "R11");
    // R1 misaligned, R2 out of range
    op(12'h101, 1, 32'hDEAD_BEEF, 0, "R1");
    op(12'h102, 0, 0, 1, "R1");
    op(12'h100, 0, 0, 1, "R1");
    op(12'h148, 1, 32'h5555_5555, 1, "R2");
    op(12'h148, 0, 0, 1, "R2");
    op(12'hFFC, 1, 32'h7777_7777, 1, "R2");
    op(12'h144, 0, 0, 1, "R2");
    // R10 hold with idle cycles
    op(12'h098, 0, 0, 1, "R10");
    op(12'h010, 1, 32'h0BAD_0BAD, 0, "R10");
    op(12'h000, 0, 0, 0, "R10");
    // random traffic
    for (int k = 0; k < 4000; k++) begin
      int w; logic [11:0] a; bit we, re;
      w = ($urandom % 8 == 0) ? int'($urandom % 1024) : int'($urandom % 90);
      a = 12'(w * 4);
      if ($urandom % 16 == 0) a[1:0] = 2'($urandom % 3 + 1);
      we = $urandom % 2 == 1;
      re = $urandom % 3 != 0;
      op(a, we, $urandom, re,
         (a[1:0] != 0) ? "R1" : (w >= NW) ? "R2" : tag_of(w));
    end
    // second reset with new straps: sticky words released
    strap_i = 32'h0F0F_A5A5; mod_dis_i = 32'h0000_0200;
    do_reset();
    op(12'h004, 0, 0, 1, "R7");
    op(12'h07C, 0, 0, 1, "R7");
    op(12'h070, 0, 0, 1, "R5");
    op(12'h06C, 0, 0, 1, "R6");
    op(12'h09C, 0, 0, 1, "R8");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule